// File: doc/BRIEF.md
# Triggered Capture Controller

This block sequences a 34-channel sampling front end. A small set of configuration registers selects which channels are kept, how fast samples are taken and what condition starts recording. Once armed, it produces a sample strobe from the fast base clock. The strobe comes from a programmable divider, from every base cycle, or from an external strobe input. On each strobe it evaluates a per-channel trigger that mixes level and transition conditions. From the triggering sample onward it writes each masked sample into an external capture memory.

Recording stops when the number of stored samples reaches a programmable full threshold. By default that threshold sits a fixed margin below the true memory depth, to leave room for pipeline latency downstream. The block reports the fill level, the number of base-clock cycles spent capturing, and three status flags: triggered, memory available and capturing. An abort input ends a capture at once.

Top module: `cap_ctrl`

## Requirements
- R1: After reset, st_triggered, st_mem_avail, st_capturing and mem_we are 0, and fill_level and duration are 0.
- R2: Configuration is written through cfg_we/cfg_addr/cfg_wdata. The addresses are: 0 channel enable (reset all ones), 1 divider maximum (reset 0), 2 trigger value, 3 transition mask, 4 care mask (these three reset 0), 5 full threshold (reset DEPTH-16), and 6 clock mode (reset 0).
- R3: In clock mode 0 (divided), the first strobe after arming falls DIV+1 base cycles after the arming edge, and further strobes follow every DIV+1 cycles. A divider maximum of 0 gives a strobe on every cycle.
- R4: In clock mode 1 (full rate) a strobe occurs on every cycle, whatever the divider holds. In clock mode 2 (external) a strobe occurs only in cycles where ext_tick is high.
- R5: For a channel set in the care mask but clear in the transition mask, the trigger requires the masked sample bit to equal the trigger value bit.
- R6: For a channel set in both the care mask and the transition mask, the trigger requires the bit to equal the value bit in the current strobe sample and to differ from it in the previous strobe sample of the same capture. The first strobe after arming cannot meet this. A transition mask bit whose care bit is clear has no effect.
- R7: With an all-zero care mask, the first strobe triggers. The triggering sample is the first one stored.
- R8: Channels cleared in the enable mask read as zero, both for the trigger comparison and in the stored word.
- R9: Each stored sample raises mem_wdata/mem_we for one cycle, in the cycle after its strobe. mem_addr starts at 0 and rises by one per write, and fill_level equals the number of writes.
- R10: The write that brings fill_level to the threshold clears st_mem_avail and st_capturing in the same cycle that it appears. No write follows it.
- R11: duration counts base-clock cycles while st_capturing is high, in every clock mode.
- R12: abort clears st_capturing at the next edge and blocks the trigger and the write of that cycle. Afterwards fill_level stays frozen and st_mem_avail keeps its value.
- R13: arm starts a capture only while idle. It clears st_triggered, fill_level and duration, and sets st_mem_avail and st_capturing. While capturing, arm is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | CH | Configuration write data |
| arm | input | 1 | Start a capture when idle |
| abort | input | 1 | Stop the running capture |
| ext_tick | input | 1 | External sample strobe for clock mode 2 |
| smp_in | input | CH | Channel inputs |
| mem_we | output | 1 | Capture memory write enable |
| mem_addr | output | AW | Capture memory write address |
| mem_wdata | output | CH | Masked sample to store |
| fill_level | output | AW+1 | Samples stored in this capture |
| duration | output | DUR_W | Base cycles spent capturing |
| st_triggered | output | 1 | Trigger condition has been met |
| st_mem_avail | output | 1 | Capture memory has room below the threshold |
| st_capturing | output | 1 | Capture running |

## Verification
Abort and the sample strobe can land in the same cycle. The case that matters is an abort arriving on the very strobe whose sample meets the trigger. The bench provokes it by arming with a one-bit level trigger and then, at one falling edge, raising the matching sample bit and abort together. It judges the outcome at the ports: st_triggered must stay 0, no write may appear and fill_level must stay 0. A second same-cycle case is the final write that also closes the capture. There the bench requires mem_we high while st_capturing and st_mem_avail fall in that same cycle, and it checks that no write comes later.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    CM_DIV  = 2'd0,
    CM_FULL = 2'd1,
    CM_EXT  = 2'd2
  } clk_mode_e;

  localparam logic [2:0] RA_EN    = 3'd0;
  localparam logic [2:0] RA_DIV   = 3'd1;
  localparam logic [2:0] RA_VAL   = 3'd2;
  localparam logic [2:0] RA_EDG   = 3'd3;
  localparam logic [2:0] RA_CARE  = 3'd4;
  localparam logic [2:0] RA_THR   = 3'd5;
  localparam logic [2:0] RA_MODE  = 3'd6;
endpackage

// File: rtl/cap_cfg_regs.sv
module cap_cfg_regs
  import cap_pkg::*;
#(
  parameter int CH     = 34,
  parameter int DIV_W  = 16,
  parameter int FW     = 11,
  parameter int THR_RST = 1008
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [2:0]       addr,
  input  logic [CH-1:0]    wdata,
  output logic [CH-1:0]    en_mask,
  output logic [DIV_W-1:0] div_max,
  output logic [CH-1:0]    trg_val,
  output logic [CH-1:0]    trg_edg,
  output logic [CH-1:0]    trg_care,
  output logic [FW-1:0]    thr,
  output clk_mode_e        mode
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_mask  <= '1;
      div_max  <= '0;
      trg_val  <= '0;
      trg_edg  <= '0;
      trg_care <= '0;
      thr      <= FW'(THR_RST);
      mode     <= CM_DIV;
    end else if (we) begin
      case (addr)
        RA_EN:   en_mask  <= wdata;
        RA_DIV:  div_max  <= DIV_W'(wdata);
        RA_VAL:  trg_val  <= wdata;
        RA_EDG:  trg_edg  <= wdata;
        RA_CARE: trg_care <= wdata;
        RA_THR:  thr      <= FW'(wdata);
        RA_MODE: mode     <= clk_mode_e'(wdata[1:0]);
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cap_strobe.sv
module cap_strobe
  import cap_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             run,
  input  clk_mode_e        mode,
  input  logic [DIV_W-1:0] div_max,
  input  logic             ext_tick,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic             div_hit;

  assign div_hit = (cnt_q >= div_max);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      cnt_q <= '0;
    end else if (mode == CM_DIV) begin
      cnt_q <= div_hit ? '0 : cnt_q + 1'b1;
    end
  end

  always_comb begin
    case (mode)
      CM_DIV:  tick = run && div_hit;
      CM_FULL: tick = run;
      CM_EXT:  tick = run && ext_tick;
      default: tick = 1'b0;
    endcase
  end
endmodule

// File: rtl/cap_trigger.sv
module cap_trigger #(
  parameter int CH = 34
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          tick,
  input  logic [CH-1:0] samp,
  input  logic [CH-1:0] trg_val,
  input  logic [CH-1:0] trg_edg,
  input  logic [CH-1:0] trg_care,
  output logic          hit
);
  logic [CH-1:0] prev_q;
  logic          prev_vld;
  logic [CH-1:0] ch_ok;

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      prev_q   <= '0;
      prev_vld <= 1'b0;
    end else if (tick) begin
      prev_q   <= samp;
      prev_vld <= 1'b1;
    end
  end

  for (genvar i = 0; i < CH; i++) begin : g_ch
    assign ch_ok[i] = !trg_care[i] ||
                      (trg_edg[i] ? (prev_vld && (samp[i] == trg_val[i]) && (prev_q[i] != trg_val[i]))
                                  : (samp[i] == trg_val[i]));
  end

  assign hit = tick && (&ch_ok);
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import cap_pkg::*;
#(
  parameter int CH     = 34,
  parameter int DEPTH  = 1024,
  parameter int MARGIN = 16,
  parameter int DIV_W  = 16,
  parameter int DUR_W  = 32,
  localparam int AW    = $clog2(DEPTH),
  localparam int FW    = AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [CH-1:0]    cfg_wdata,
  input  logic             arm,
  input  logic             abort,
  input  logic             ext_tick,
  input  logic [CH-1:0]    smp_in,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [CH-1:0]    mem_wdata,
  output logic [FW-1:0]    fill_level,
  output logic [DUR_W-1:0] duration,
  output logic             st_triggered,
  output logic             st_mem_avail,
  output logic             st_capturing
);
  localparam logic [FW-1:0] DEPTH_FW = FW'(DEPTH);

  logic [CH-1:0]    en_mask, trg_val, trg_edg, trg_care;
  logic [DIV_W-1:0] div_max;
  logic [FW-1:0]    thr;
  clk_mode_e        mode;
  logic             tick, hit, arm_go, store, last_wr;
  logic [CH-1:0]    samp;
  logic [FW-1:0]    fill_nx;

  cap_cfg_regs #(.CH(CH), .DIV_W(DIV_W), .FW(FW), .THR_RST(DEPTH - MARGIN)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .en_mask(en_mask), .div_max(div_max), .trg_val(trg_val), .trg_edg(trg_edg),
    .trg_care(trg_care), .thr(thr), .mode(mode)
  );

  assign arm_go = arm && !st_capturing;
  assign samp   = smp_in & en_mask;

  cap_strobe #(.DIV_W(DIV_W)) u_strobe (
    .clk(clk), .rst(rst), .restart(arm_go), .run(st_capturing), .mode(mode),
    .div_max(div_max), .ext_tick(ext_tick), .tick(tick)
  );

  cap_trigger #(.CH(CH)) u_trig (
    .clk(clk), .rst(rst), .restart(arm_go), .tick(tick), .samp(samp),
    .trg_val(trg_val), .trg_edg(trg_edg), .trg_care(trg_care), .hit(hit)
  );

  assign store   = tick && !abort && (st_triggered || hit);
  assign fill_nx = fill_level + 1'b1;
  assign last_wr = (fill_nx >= thr) || (fill_nx == DEPTH_FW);

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_we       <= 1'b0;
      mem_addr     <= '0;
      mem_wdata    <= '0;
      fill_level   <= '0;
      duration     <= '0;
      st_triggered <= 1'b0;
      st_mem_avail <= 1'b0;
      st_capturing <= 1'b0;
    end else if (arm_go) begin
      mem_we       <= 1'b0;
      fill_level   <= '0;
      duration     <= '0;
      st_triggered <= 1'b0;
      st_mem_avail <= 1'b1;
      st_capturing <= 1'b1;
    end else begin
      mem_we <= 1'b0;
      if (st_capturing) duration <= duration + 1'b1;
      if (abort) begin
        st_capturing <= 1'b0;
      end else begin
        if (hit) st_triggered <= 1'b1;
        if (store) begin
          mem_we     <= 1'b1;
          mem_addr   <= fill_level[AW-1:0];
          mem_wdata  <= samp;
          fill_level <= fill_nx;
          if (last_wr) begin
            st_mem_avail <= 1'b0;
            st_capturing <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/cap_ctrl_chk.sv
module cap_ctrl_chk #(
  parameter int AW    = 10,
  parameter int DUR_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             arm,
  input logic             abort,
  input logic             mem_we,
  input logic [AW-1:0]    mem_addr,
  input logic [AW:0]      fill_level,
  input logic [DUR_W-1:0] duration,
  input logic             st_triggered,
  input logic             st_mem_avail,
  input logic             st_capturing
);
  AST_WE_AFTER_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(st_capturing));  // R9

  AST_WE_ADDR_FILL: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr == $past(fill_level[AW-1:0])) && (fill_level == $past(fill_level) + 1'b1));  // R9

  AST_FULL_CLOSES: assert property (@(posedge clk) disable iff (rst)
    $fell(st_mem_avail) |-> mem_we && !st_capturing);  // R10

  AST_TRIG_STORES: assert property (@(posedge clk) disable iff (rst)
    $rose(st_triggered) |-> mem_we);  // R7

  AST_DUR_STEP: assert property (@(posedge clk) disable iff (rst)
    (st_capturing && $past(st_capturing)) |-> (duration == $past(duration) + 1'b1));  // R11

  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (rst)
    $past(abort) && !$past(rst) |-> !st_capturing && !mem_we);  // R12

  AST_FILL_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!$past(st_capturing) && !$past(arm) && !$past(rst)) |-> $stable(fill_level));  // R12
endmodule

bind cap_ctrl cap_ctrl_chk #(.AW(AW), .DUR_W(DUR_W)) u_chk (
  .clk(clk), .rst(rst), .arm(arm), .abort(abort), .mem_we(mem_we),
  .mem_addr(mem_addr), .fill_level(fill_level), .duration(duration),
  .st_triggered(st_triggered), .st_mem_avail(st_mem_avail), .st_capturing(st_capturing)
);

// File: tb/tb_cap_ctrl.sv
module tb_cap_ctrl;
  localparam int CH = 34;
  localparam int DEPTH = 1024;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [2:0]    cfg_addr = '0;
  logic [CH-1:0] cfg_wdata = '0;
  logic          arm = 1'b0, abort = 1'b0, ext_tick = 1'b0;
  logic [CH-1:0] smp_in = '0;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [CH-1:0] mem_wdata;
  logic [AW:0]   fill_level;
  logic [31:0]   duration;
  logic          st_triggered, st_mem_avail, st_capturing;

  cap_ctrl dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .arm(arm), .abort(abort), .ext_tick(ext_tick), .smp_in(smp_in),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .fill_level(fill_level), .duration(duration), .st_triggered(st_triggered),
    .st_mem_avail(st_mem_avail), .st_capturing(st_capturing)
  );

  always #10 clk = ~clk;

  int checks = 0, failures = 0, cyc = 0, arm_cyc = 0, wr_n = 0;
  int wr_cyc [16];
  logic [AW-1:0] last_addr;
  logic [CH-1:0] last_data;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (!rst && mem_we) begin
      if (wr_n < 16) wr_cyc[wr_n] = cyc;
      wr_n = wr_n + 1;
      last_addr = mem_addr;
      last_data = mem_wdata;
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] a, input logic [CH-1:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic arm_now();
    @(negedge clk); wr_n = 0; arm = 1'b1;
    @(negedge clk); arm = 1'b0; arm_cyc = cyc;
  endtask

  task automatic stop_now();
    @(negedge clk); abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // care, transition mask, value, first sample, second sample, expected trigger
  localparam logic [170:0] VEC [10] = '{
    {34'h1, 34'h0, 34'h1, 34'h0, 34'h1, 1'b1},
    {34'h1, 34'h0, 34'h1, 34'h0, 34'h0, 1'b0},
    {34'h1, 34'h1, 34'h1, 34'h0, 34'h1, 1'b1},
    {34'h1, 34'h1, 34'h1, 34'h1, 34'h1, 1'b0},
    {34'h1, 34'h1, 34'h0, 34'h1, 34'h0, 1'b1},
    {34'h3, 34'h1, 34'h3, 34'h2, 34'h3, 1'b1},
    {34'h3, 34'h1, 34'h3, 34'h2, 34'h1, 1'b0},
    {34'h2, 34'h1, 34'h2, 34'h0, 34'h0, 1'b0},
    {34'h0, 34'h0, 34'h0, 34'h5, 34'h6, 1'b1},
    {34'h2_0000_0000, 34'h0, 34'h2_0000_0000, 34'h0, 34'h2_0000_0000, 1'b1}
  };

  initial begin
    #(20 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 flags", {st_triggered, st_mem_avail, st_capturing, mem_we}, 0);
    check("R1 fill", fill_level, 0);
    check("R1 duration", duration, 0);

    // R2 default threshold DEPTH-16, full-rate clock mode
    cfg(3'd6, 34'd1);
    arm_now();
    for (int i = 0; i < 2000 && st_capturing; i++) @(negedge clk);
    idle(2);
    check("R2 R10 default threshold fill", fill_level, DEPTH - 16);
    check("R9 write count", wr_n, DEPTH - 16);
    check("R9 last address", last_addr, DEPTH - 17);
    check("R10 mem_avail cleared", {st_mem_avail, st_capturing}, 0);
    check("R11 duration full rate", duration, DEPTH - 16);

    // R5 R6 R7 trigger table, full-rate mode
    for (int v = 0; v < 10; v++) begin
      stop_now();
      cfg(3'd4, VEC[v][170:137]);
      cfg(3'd3, VEC[v][136:103]);
      cfg(3'd2, VEC[v][102:69]);
      @(negedge clk); smp_in = VEC[v][68:35]; arm = 1'b1;
      @(negedge clk); arm = 1'b0;
      @(negedge clk); smp_in = VEC[v][34:1];
      @(negedge clk);
      check($sformatf("R5 R6 R7 trigger vector %0d", v), st_triggered, VEC[v][0]);
    end
    stop_now();

    // R3 divided mode, divider 3, threshold 2, care none
    cfg(3'd4, 0); cfg(3'd6, 0); cfg(3'd1, 3); cfg(3'd5, 2);
    arm_now();
    idle(12);
    check("R3 first strobe write", wr_cyc[0] - arm_cyc, 4);
    check("R3 spacing div3", wr_cyc[1] - wr_cyc[0], 4);
    check("R10 writes stop at threshold", wr_n, 2);
    check("R11 duration divided", duration, 8);
    check("R7 triggered", st_triggered, 1);

    // R3 divider 0
    cfg(3'd1, 0); cfg(3'd5, 3);
    arm_now();
    idle(6);
    check("R3 div0 first", wr_cyc[0] - arm_cyc, 1);
    check("R3 div0 spacing", wr_cyc[2] - wr_cyc[1], 1);

    // R4 full rate ignores divider
    cfg(3'd1, 5); cfg(3'd6, 1);
    arm_now();
    idle(6);
    check("R4 full first", wr_cyc[0] - arm_cyc, 1);
    check("R4 full spacing", wr_cyc[1] - wr_cyc[0], 1);

    // R4 external strobe
    cfg(3'd6, 2); cfg(3'd5, 2);
    arm_now();
    idle(5);
    check("R4 ext no tick", fill_level, 0);
    @(negedge clk); ext_tick = 1'b1;
    @(negedge clk); ext_tick = 1'b0;
    check("R4 ext one tick", fill_level, 1);
    idle(3);
    check("R4 ext hold", fill_level, 1);
    @(negedge clk); ext_tick = 1'b1;
    @(negedge clk); ext_tick = 1'b0;
    check("R4 ext second", {fill_level, st_capturing}, {11'd2, 1'b0});

    // R8 enable mask: masked bit cannot trigger, and stored data is masked
    cfg(3'd6, 1); cfg(3'd5, 100); cfg(3'd0, 34'h0F0);
    cfg(3'd4, 1); cfg(3'd3, 0); cfg(3'd2, 1);
    smp_in = 34'h3_FFFF_FFFF;
    arm_now();
    idle(4);
    check("R8 masked trigger", {st_triggered, fill_level}, 0);
    stop_now();
    cfg(3'd4, 0);
    arm_now();
    idle(2);
    check("R8 stored data masked", last_data, 34'h0F0);
    stop_now();
    cfg(3'd0, 34'h3_FFFF_FFFF);

    // R13 arm ignored while capturing
    arm_now();
    idle(3);
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0;
    check("R13 arm ignored", fill_level, 5);

    // R12 abort freezes
    stop_now();
    check("R12 abort flags", {st_capturing, st_mem_avail}, 2'b01);
    begin
      logic [AW:0] f0;
      int n0;
      f0 = fill_level; n0 = wr_n;
      idle(5);
      check("R12 fill frozen", fill_level, f0);
      check("R12 no writes", wr_n, n0);
    end

    // R12 abort on the triggering strobe
    cfg(3'd4, 1); cfg(3'd2, 1); smp_in = 0;
    arm_now();
    idle(2);
    @(negedge clk); smp_in = 1; abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    idle(2);
    check("R12 abort beats trigger", {st_triggered, st_capturing}, 0);
    check("R12 abort no write", {fill_level, 32'(wr_n)}, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule